// File: doc/BRIEF.md
# Stopwatch Control State Machine

This block is the controller of a stopwatch. A single start/stop push button and a clear switch drive it. It produces the enable and clear strobes for external time counters. The controller treats a press and a release of the button as two separate events. A press moves the machine into a short-lived state, and the release moves it into a steady state. This lets one button both start and stop the count without the count toggling repeatedly while the button is held.

The 3-bit state register is driven straight out so that the current state can be observed. The binary code of each state is set by a parameter of the top module. A power-on state, CLEAR, is kept apart from the state that zeroes the counters on request, ZERO. The button and switch inputs are assumed to be synchronous and already debounced. Every transition happens on the rising clock edge. Reset is synchronous and active-high.

Top module: `stopwatch_ctrl`

## Requirements
- R1: With `rst` high at a rising edge, the state after that edge is CLEAR, whatever `btn` and `clr_sw` are, with `cnt_clr`=1 and `cnt_en`=0.
- R2: `state_q` carries the state code. The default codes are CLEAR=0, ZERO=1, START=2, COUNT=3, STOP=4 and STOPPED=5, and no other value appears out of reset.
- R3: In CLEAR or ZERO, with `btn`=1 and `clr_sw`=0, the next state is START.
- R4: In CLEAR, `clr_sw`=1 leads to ZERO. In ZERO, `clr_sw`=1 keeps the state in ZERO even while `btn`=1. In either state, `btn`=0 with `clr_sw`=0 holds the state.
- R5: START is held while `btn`=1 and moves to COUNT when `btn`=0.
- R6: In COUNT, `btn`=1 moves to STOP. `btn`=0 holds COUNT, and `clr_sw` has no effect there.
- R7: STOP is held while `btn`=1 and moves to STOPPED when `btn`=0.
- R8: In STOPPED, `clr_sw`=1 leads to ZERO and takes priority over `btn`. `btn`=1 with `clr_sw`=0 leads to START. Otherwise STOPPED is held.
- R9: `cnt_en` is 1 exactly in START and COUNT.
- R10: `cnt_clr` is 1 exactly in CLEAR and ZERO.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active-high |
| btn | input | 1 | Start/stop button level, 1 while pressed |
| clr_sw | input | 1 | Clear switch level, 1 when closed |
| state_q | output | 3 | Current state code |
| cnt_en | output | 1 | Counter enable |
| cnt_clr | output | 1 | Counter clear |

## Verification
The inputs are sampled at one rising edge. The new state, and the `cnt_en` and `cnt_clr` values decoded from it, are visible right after that same edge, so every result is due exactly one cycle after its stimulus. The bench changes the inputs on the falling edge and queues the expected state for the next rising edge. It compares one time unit after that edge, so each expected item lines up with exactly one clock edge.

// File: rtl/sw_ctrl_pkg.sv
package sw_ctrl_pkg;
  localparam int ST_W = 3;
  typedef logic [ST_W-1:0] st_code_t;

  typedef struct packed {
    st_code_t clear;
    st_code_t zero;
    st_code_t start;
    st_code_t count;
    st_code_t stop;
    st_code_t stopped;
  } st_map_t;

  localparam st_map_t DEF_MAP = '{
    clear:   3'd0,
    zero:    3'd1,
    start:   3'd2,
    count:   3'd3,
    stop:    3'd4,
    stopped: 3'd5
  };
endpackage

// File: rtl/sw_next.sv
module sw_next
  import sw_ctrl_pkg::*;
#(
  parameter st_map_t MAP = DEF_MAP
) (
  input  st_code_t cur,
  input  logic     btn,
  input  logic     clr_sw,
  output st_code_t nxt
);
  always_comb begin
    if (cur == MAP.clear) begin
      if (clr_sw)   nxt = MAP.zero;
      else if (btn) nxt = MAP.start;
      else          nxt = MAP.clear;
    end else if (cur == MAP.zero) begin
      if (btn && !clr_sw) nxt = MAP.start;
      else                nxt = MAP.zero;
    end else if (cur == MAP.start) begin
      nxt = btn ? MAP.start : MAP.count;
    end else if (cur == MAP.count) begin
      nxt = btn ? MAP.stop : MAP.count;
    end else if (cur == MAP.stop) begin
      nxt = btn ? MAP.stop : MAP.stopped;
    end else if (cur == MAP.stopped) begin
      if (clr_sw)   nxt = MAP.zero;
      else if (btn) nxt = MAP.start;
      else          nxt = MAP.stopped;
    end else begin
      nxt = MAP.clear;  // unused code: fall back to power-on state
    end
  end
endmodule

// File: rtl/sw_decode.sv
module sw_decode
  import sw_ctrl_pkg::*;
#(
  parameter st_map_t MAP = DEF_MAP
) (
  input  st_code_t cur,
  output logic     cnt_en,
  output logic     cnt_clr
);
  localparam int NRUN = 2;
  localparam int NZRO = 2;
  localparam st_code_t RUN_SET [NRUN] = '{MAP.start, MAP.count};
  localparam st_code_t ZRO_SET [NZRO] = '{MAP.clear, MAP.zero};

  logic [NRUN-1:0] run_hit;
  logic [NZRO-1:0] zro_hit;

  for (genvar i = 0; i < NRUN; i++) begin : g_run
    assign run_hit[i] = (cur == RUN_SET[i]);
  end
  for (genvar j = 0; j < NZRO; j++) begin : g_zro
    assign zro_hit[j] = (cur == ZRO_SET[j]);
  end

  assign cnt_en  = |run_hit;
  assign cnt_clr = |zro_hit;
endmodule

// File: rtl/stopwatch_ctrl.sv
module stopwatch_ctrl
  import sw_ctrl_pkg::*;
#(
  parameter st_map_t MAP = DEF_MAP
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            btn,
  input  logic            clr_sw,
  output logic [ST_W-1:0] state_q,
  output logic            cnt_en,
  output logic            cnt_clr
);
  st_code_t cur_q;
  st_code_t nxt;

  sw_next #(.MAP(MAP)) u_next (
    .cur    (cur_q),
    .btn    (btn),
    .clr_sw (clr_sw),
    .nxt    (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) cur_q <= MAP.clear;
    else     cur_q <= nxt;
  end

  sw_decode #(.MAP(MAP)) u_dec (
    .cur     (cur_q),
    .cnt_en  (cnt_en),
    .cnt_clr (cnt_clr)
  );

  assign state_q = cur_q;
endmodule

// File: rtl/sw_ctrl_chk.sv
module sw_ctrl_chk
  import sw_ctrl_pkg::*;
#(
  parameter st_map_t MAP = DEF_MAP
) (
  input logic            clk,
  input logic            rst,
  input logic            btn,
  input logic            clr_sw,
  input logic [ST_W-1:0] state_q,
  input logic            cnt_en,
  input logic            cnt_clr
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (state_q == MAP.clear));

  assert_legal_code_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == MAP.clear) || (state_q == MAP.zero) || (state_q == MAP.start) ||
    (state_q == MAP.count) || (state_q == MAP.stop) || (state_q == MAP.stopped));

  assert_press_start_R3: assert property (@(posedge clk) disable iff (rst)
    ((state_q == MAP.clear || state_q == MAP.zero) && btn && !clr_sw)
      |=> (state_q == MAP.start));

  assert_clear_zero_R4: assert property (@(posedge clk) disable iff (rst)
    ((state_q == MAP.clear || state_q == MAP.zero) && clr_sw)
      |=> (state_q == MAP.zero));

  assert_release_count_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == MAP.start && !btn) |=> (state_q == MAP.count));

  assert_press_stop_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == MAP.count && btn) |=> (state_q == MAP.stop));

  assert_count_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == MAP.count && !btn) |=> $stable(state_q));

  assert_release_stopped_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == MAP.stop && !btn) |=> (state_q == MAP.stopped));

  assert_stopped_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == MAP.stopped && clr_sw) |=> (state_q == MAP.zero));

  assert_en_rise_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(cnt_en) |-> (state_q == MAP.start));

  assert_en_clr_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(cnt_en && cnt_clr));
endmodule

bind stopwatch_ctrl sw_ctrl_chk #(.MAP(MAP)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .btn     (btn),
  .clr_sw  (clr_sw),
  .state_q (state_q),
  .cnt_en  (cnt_en),
  .cnt_clr (cnt_clr)
);

// File: tb/tb_stopwatch_ctrl.sv
`timescale 1ns/1ps
module tb_stopwatch_ctrl;
  localparam logic [2:0] S_CLEAR = 3'd0, S_ZERO = 3'd1, S_START = 3'd2,
                         S_COUNT = 3'd3, S_STOP = 3'd4, S_STOPPED = 3'd5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn = 1'b0;
  logic clr_sw = 1'b0;
  logic [2:0] state_q;
  logic cnt_en, cnt_clr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0] st;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  stopwatch_ctrl dut (
    .clk(clk), .rst(rst), .btn(btn), .clr_sw(clr_sw),
    .state_q(state_q), .cnt_en(cnt_en), .cnt_clr(cnt_clr)
  );

  // Driver: set inputs away from the rising edge and queue the state due after it
  task automatic step(input logic r, input logic b, input logic c,
                      input logic [2:0] st, input string tag);
    @(negedge clk);
    rst = r; btn = b; clr_sw = c;
    q.push_back('{st: st, tag: tag});
  endtask

  // Monitor: the item queued before a rising edge is due just after it
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      logic ee, ec;
      e = q.pop_front();
      ee = (e.st == S_START) || (e.st == S_COUNT);   // R9
      ec = (e.st == S_CLEAR) || (e.st == S_ZERO);    // R10
      total++;
      if (state_q !== e.st) begin
        bad++;
        $display("FAIL %s state actual=%0d expected=%0d", e.tag, state_q, e.st);
      end
      total++;
      if (cnt_en !== ee) begin
        bad++;
        $display("FAIL R9 (%s) cnt_en actual=%0b expected=%0b", e.tag, cnt_en, ee);
      end
      total++;
      if (cnt_clr !== ec) begin
        bad++;
        $display("FAIL R10 (%s) cnt_clr actual=%0b expected=%0b", e.tag, cnt_clr, ec);
      end
      total++;
      if (state_q > 3'd5) begin
        bad++;
        $display("FAIL R2 illegal code actual=%0d expected<=5", state_q);
      end
    end
  end

  initial begin
    step(1, 0, 0, S_CLEAR,   "R1 reset");
    step(1, 1, 1, S_CLEAR,   "R1 reset ignores inputs");
    step(0, 0, 0, S_CLEAR,   "R4 CLEAR hold");
    step(0, 1, 0, S_START,   "R3 press from CLEAR");
    step(0, 1, 0, S_START,   "R5 START held");
    step(0, 0, 0, S_COUNT,   "R5 release to COUNT");
    step(0, 0, 1, S_COUNT,   "R6 clear ignored in COUNT");
    step(0, 1, 0, S_STOP,    "R6 press to STOP");
    step(0, 1, 0, S_STOP,    "R7 STOP held");
    step(0, 0, 0, S_STOPPED, "R7 release to STOPPED");
    step(0, 0, 0, S_STOPPED, "R8 STOPPED hold");
    step(0, 1, 0, S_START,   "R8 resume");
    step(0, 0, 0, S_COUNT,   "R5 release again");
    step(0, 1, 0, S_STOP,    "R6 stop again");
    step(0, 0, 0, S_STOPPED, "R7 stopped again");
    step(0, 1, 1, S_ZERO,    "R8 clear beats button");
    step(0, 1, 1, S_ZERO,    "R4 ZERO held under clear");
    step(0, 0, 0, S_ZERO,    "R4 ZERO idle hold");
    step(0, 1, 0, S_START,   "R3 press from ZERO");
    step(0, 0, 0, S_COUNT,   "R5 count");
    step(1, 1, 0, S_CLEAR,   "R1 reset mid-run");
    step(0, 1, 1, S_ZERO,    "R4 CLEAR to ZERO");
    step(0, 0, 0, S_ZERO,    "R4 ZERO hold");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule